// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Controller

This block produces the processor reset for a small supply supervisor. Three things can hold the processor in reset. The first is a power-up stretch that starts when the supply-good flag from an external comparator goes high. The second is a low-supply condition, which forces reset in the same cycle. The third is a watchdog that expires when the host stops pulsing the memory chip-select pin, which also acts as the watchdog kick. All three sources merge into one stretched reset. The reset is driven in both polarities.

The watchdog period comes from a two-bit selection code held in a configuration register. A write port updates the register. None of the reset sources clears it, so a chosen period survives a supply loss. One code value turns the watchdog off, and that value is also the value after initialisation. Every period is a parameter counted in clock ticks, so a simulation can use short periods.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block asserts reset (`rst_hi`=1, `rst_lo_n`=0) and sets the selection code to 2'b11.
- R2: After initialisation, or after supply-good rises, reset stays asserted until POR_TICKS cycles of good supply have elapsed. Only then is it released.
- R3: With selection code 2'b11 the watchdog never expires, whatever `cs_n` does.
- R4: With code 2'b10, reset is asserted WD_TICKS_10 cycles after the last restart of the watchdog if no kick arrives. That reset lasts RST_TICKS cycles. The watchdog count is held at zero while reset is asserted.
- R5: A low pulse on `cs_n` that lasts at least KICK_MIN cycles restarts the watchdog count on the rising edge that ends it. A shorter pulse is ignored.
- R6: Code 2'b01 gives a period of WD_TICKS_01 cycles and code 2'b00 gives WD_TICKS_00 cycles.
- R7: When `supply_ok` is low, `rst_hi` goes high combinationally in the same cycle. It stays high until supply is good again and the power-up stretch of R2 has elapsed.
- R8: `rst_lo_n` is always the complement of `rst_hi`.
- R9: A write through `cfg_wr_en`/`cfg_wr_code` loads the new code and restarts the watchdog count from zero.
- R10: The selection code survives loss of supply. After supply returns, the watchdog uses the code written before the loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low initialisation |
| supply_ok | input | 1 | Digitised supply-good flag from the comparator |
| cs_n | input | 1 | Memory chip select, also used as the watchdog kick (asynchronous) |
| cfg_wr_en | input | 1 | One-cycle strobe that writes the selection code |
| cfg_wr_code | input | 2 | New watchdog selection code |
| rst_hi | output | 1 | Processor reset, active high |
| rst_lo_n | output | 1 | Processor reset, active low |

## Verification
The bench runs its own cycle-level reference model and goes after these timing edges:
- **Exact watchdog periods.** It measures the length of each period for every code. An off-by-one counter shows up as a low phase one cycle too long or too short.
- **Pulse width of the kick.** Pulses of KICK_MIN cycles and pulses one cycle shorter both drive the watchdog. A comparator with the wrong sense would either let the watchdog expire while the host is kicking, or keep it quiet on pulses that are too short.
- **Supply drop.** The bench samples the output in the same cycle that supply drops. A registered path, instead of a combinational one, is caught there.
- **Code survival.** The bench re-measures the period after supply returns. A design that clears the code on a supply loss would fall back to the watchdog-off code.
- **Restart on write.** A rewrite late in a period must restart the full period. A design that misses the restart would expire early.

// File: rtl/sup_rst_pkg.sv
// Package: shared types and helpers for the supervisor reset controller.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_rst_pkg;

    // Watchdog period selection; WD_OFF is also the initial value.
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Larger of two tick counts, used to size shared counters.
    function automatic int unsigned tick_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sup_cs_kick.sv
// Module: sup_cs_kick
// Synchronises the chip-select pin and emits a one-cycle kick on the
// rising edge that ends a low pulse of at least KICK_MIN synchronised cycles.
// Assumes: cs_n is asynchronous to clk; KICK_MIN >= 1.
module sup_cs_kick #(
    parameter int unsigned KICK_MIN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic kick
);
    localparam int unsigned LW = $clog2(KICK_MIN + 1);
    localparam logic [LW-1:0] LOW_SAT = LW'(KICK_MIN);

    logic          sync1, sync2, sync3;
    logic [LW-1:0] low_cnt;

    // Two-flop synchroniser plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
            sync3 <= 1'b1;
        end else begin
            sync1 <= cs_n;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    // Counts synchronised low cycles, saturating at the minimum width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (sync2)
            low_cnt <= '0;
        else if (low_cnt != LOW_SAT)
            low_cnt <= low_cnt + 1'b1;
    end

    // Kick on the rising edge of a long enough low pulse.
    always_comb kick = sync2 && !sync3 && (low_cnt == LOW_SAT);

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick); // R5

endmodule

// File: rtl/sup_wdog.sv
// Module: sup_wdog
// Holds the watchdog selection code and counts the watchdog period.
// Raises expire for one cycle when the period ends without a kick.
// Assumes: rst_in is the merged reset level; the code is cleared only by rst_n.
module sup_wdog
    import sup_rst_pkg::*;
#(
    parameter int unsigned WD_TICKS_00 = 70_000_000,
    parameter int unsigned WD_TICKS_01 = 30_000_000,
    parameter int unsigned WD_TICKS_10 = 10_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rst_in,
    input  logic       kick,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output logic       expire
);
    localparam int unsigned WMAX = tick_max(tick_max(WD_TICKS_00, WD_TICKS_01), WD_TICKS_10);
    localparam int unsigned CW   = $clog2(WMAX + 1);

    wd_sel_e       code;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic          off;

    // Selection register: set to off at initialisation, written by the port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code <= WD_OFF;
        else if (wr_en)
            code <= wd_sel_e'(wr_code);
    end

    // Last count value of the selected period.
    always_comb begin
        unique case (code)
            WD_LONG:  lim_m1 = CW'(WD_TICKS_00 - 1);
            WD_MID:   lim_m1 = CW'(WD_TICKS_01 - 1);
            WD_SHORT: lim_m1 = CW'(WD_TICKS_10 - 1);
            default:  lim_m1 = '0;
        endcase
    end

    always_comb off = (code == WD_OFF);

    // Expiry is the last counted cycle with nothing restarting the count.
    always_comb expire = !rst_in && !off && !kick && !wr_en && (cnt == lim_m1);

    // Period counter: held at zero in reset, on a kick, on a write or when off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (rst_in || kick || wr_en || off || expire)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_in |=> (cnt == '0)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1); // R6
    AST_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (code == $past(wr_code)) && (cnt == '0)); // R9
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        off |-> !expire); // R3

endmodule

// File: rtl/sup_rst_stretch.sv
// Module: sup_rst_stretch
// Timer that stretches reset: reloaded with the power-up length while
// supply is low, and started with the reset length on a watchdog expiry.
// Assumes: an expiry while the stretch is running is ignored.
module sup_rst_stretch #(
    parameter int unsigned POR_TICKS = 10_000_000,
    parameter int unsigned RST_TICKS = 10_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_expire,
    output logic active
);
    localparam int unsigned TMAX = (POR_TICKS > RST_TICKS) ? POR_TICKS : RST_TICKS;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] POR_LOAD = TW'(POR_TICKS - 1);
    localparam logic [TW-1:0] RST_LOAD = TW'(RST_TICKS - 1);

    logic [TW-1:0] cnt;

    // Stretch timer: reload on low supply, count down while active, start on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_ok) begin
            active <= 1'b1;
            cnt    <= POR_LOAD;
        end else if (active) begin
            if (cnt == '0)
                active <= 1'b0;
            else
                cnt <= cnt - 1'b1;
        end else if (wd_expire) begin
            active <= 1'b1;
            cnt    <= RST_LOAD;
        end
    end

    AST_LOW_SUPPLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> active && (cnt == POR_LOAD)); // R7
    AST_RELEASE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (active && supply_ok && cnt == '0) |=> !active); // R2
    AST_EXPIRE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && supply_ok && wd_expire) |=> active && (cnt == RST_LOAD)); // R4

endmodule

// File: rtl/sup_reset_ctrl.sv
// Module: sup_reset_ctrl (top)
// Merges the power-up, low-supply and watchdog reset sources into one
// stretched reset, driven in both polarities.
// Assumes: supply_ok is already clean and digital; cs_n is asynchronous.
module sup_reset_ctrl #(
    parameter int unsigned POR_TICKS   = 10_000_000,
    parameter int unsigned RST_TICKS   = 10_000_000,
    parameter int unsigned WD_TICKS_10 = 10_000_000,
    parameter int unsigned WD_TICKS_01 = 30_000_000,
    parameter int unsigned WD_TICKS_00 = 70_000_000,
    parameter int unsigned KICK_MIN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       cs_n,
    input  logic       cfg_wr_en,
    input  logic [1:0] cfg_wr_code,
    output logic       rst_hi,
    output logic       rst_lo_n
);
    logic kick;
    logic wd_expire;
    logic stretch_on;

    sup_cs_kick #(.KICK_MIN(KICK_MIN)) kick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .kick  (kick)
    );

    sup_wdog #(
        .WD_TICKS_00 (WD_TICKS_00),
        .WD_TICKS_01 (WD_TICKS_01),
        .WD_TICKS_10 (WD_TICKS_10)
    ) wdog_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_in  (rst_hi),
        .kick    (kick),
        .wr_en   (cfg_wr_en),
        .wr_code (cfg_wr_code),
        .expire  (wd_expire)
    );

    sup_rst_stretch #(.POR_TICKS(POR_TICKS), .RST_TICKS(RST_TICKS)) stretch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .wd_expire (wd_expire),
        .active    (stretch_on)
    );

    // Low supply acts without a clock; otherwise the stretch timer decides.
    always_comb rst_hi   = !supply_ok || stretch_on;
    // Active-low copy of the same reset.
    always_comb rst_lo_n = !rst_hi;

    AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> rst_hi); // R4

endmodule

// File: tb/sup_reset_ctrl_tb_top.sv
module sup_reset_ctrl_tb_top;
    localparam int P   = 20;
    localparam int R   = 12;
    localparam int T10 = 40;
    localparam int T01 = 60;
    localparam int T00 = 90;
    localparam int KM  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic cs_n = 1'b1;
    logic cfg_wr_en = 1'b0;
    logic [1:0] cfg_wr_code = 2'b00;
    logic rst_hi, rst_lo_n;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    sup_reset_ctrl #(
        .POR_TICKS(P), .RST_TICKS(R), .WD_TICKS_10(T10),
        .WD_TICKS_01(T01), .WD_TICKS_00(T00), .KICK_MIN(KM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_code(cfg_wr_code),
        .rst_hi(rst_hi), .rst_lo_n(rst_lo_n)
    );

    // Behavioural reference state
    int m_code = 3, m_rem = P, m_wd = 0, m_low = 0;
    int m_cs[$] = '{1, 1, 1};

    function automatic int period_of(input int code);
        case (code)
            0: return T00;
            1: return T01;
            2: return T10;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model advanced on each edge, outputs compared 5 ns later.
    always @(posedge clk) begin
        bit cur_rst, kick_m, exp_m;
        int older, newer;
        if (!rst_n) begin
            m_code = 3; m_rem = P; m_wd = 0; m_low = 0;
            m_cs = '{1, 1, 1};
        end else begin
            cur_rst = !supply_ok || (m_rem > 0);
            newer = m_cs[1];
            older = m_cs[2];
            kick_m = (newer == 1) && (older == 0) && (m_low >= KM);
            exp_m = !cur_rst && m_code != 3 && !kick_m && !cfg_wr_en &&
                    (m_wd == period_of(m_code) - 1);
            if (cur_rst || kick_m || cfg_wr_en || m_code == 3 || exp_m) m_wd = 0;
            else m_wd++;
            if (!supply_ok) m_rem = P;
            else if (m_rem > 0) m_rem--;
            else if (exp_m) m_rem = R;
            if (cfg_wr_en) m_code = int'(cfg_wr_code);
            if (newer == 0) m_low = (m_low + 1 > KM) ? KM : m_low + 1;
            else m_low = 0;
            m_cs.push_front(int'(cs_n));
            void'(m_cs.pop_back());
        end
        #5;
        check(cur_req, rst_hi, !supply_ok || (m_rem > 0));
        check("R8", rst_lo_n, !rst_hi);
    end

    task automatic wr_code(input logic [1:0] c);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_code = c;
        @(negedge clk); cfg_wr_en = 1'b0;
    endtask

    task automatic run_len(input logic lvl, input int exp, input string req);
        int n = 0;
        while (rst_hi == lvl && n < 1000) begin n++; @(negedge clk); end
        checks++;
        if (n != exp) begin
            fails++;
            $display("FAIL %s: run length %0d expected %0d", req, n, exp);
        end
    endtask

    task automatic pulse(input int w);
        @(negedge clk); cs_n = 1'b0;
        repeat (w) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        bit saw;
        // R1: initialisation state
        repeat (4) @(negedge clk);
        check("R1", rst_hi, 1'b1);
        check("R1", rst_lo_n, 1'b0);
        rst_n = 1'b1;
        // R2: power-up stretch
        cur_req = "R2";
        repeat (P - 4) @(negedge clk);
        check("R2", rst_hi, 1'b1);
        repeat (8) @(negedge clk);
        check("R2", rst_hi, 1'b0);
        // R3: default code keeps the watchdog off
        cur_req = "R3";
        repeat (80) @(negedge clk); cs_n = 1'b0;
        repeat (5) @(negedge clk); cs_n = 1'b1;
        repeat (80) @(negedge clk);
        check("R3", rst_hi, 1'b0);
        // R4: short period, reset length, count held during reset
        cur_req = "R4";
        wr_code(2'b10);
        run_len(1'b0, T10, "R4");
        run_len(1'b1, R, "R4");
        run_len(1'b0, T10, "R4");
        run_len(1'b1, R, "R4");
        // R5: kicks of minimum width hold off the watchdog
        cur_req = "R5";
        saw = 0;
        for (int i = 0; i < 6; i++) begin
            repeat (30) begin @(negedge clk); saw |= rst_hi; end
            pulse(KM);
        end
        check("R5", saw, 1'b0);
        // R5: pulses one cycle too short are ignored
        for (int i = 0; i < 3; i++) begin
            repeat (30) begin @(negedge clk); saw |= rst_hi; end
            pulse(KM - 1);
        end
        check("R5", saw, 1'b1);
        while (rst_hi) @(negedge clk);
        // R6: the two longer periods
        cur_req = "R6";
        wr_code(2'b01);
        run_len(1'b0, T01, "R6");
        run_len(1'b1, R, "R6");
        wr_code(2'b00);
        run_len(1'b0, T00, "R6");
        run_len(1'b1, R, "R6");
        // R9: rewrite late in the period restarts it
        cur_req = "R9";
        repeat (70) @(negedge clk);
        wr_code(2'b00);
        run_len(1'b0, T00, "R9");
        run_len(1'b1, R, "R9");
        // R7: supply drop asserts reset in the same cycle
        cur_req = "R7";
        repeat (10) @(negedge clk);
        supply_ok = 1'b0;
        #1 check("R7", rst_hi, 1'b1);
        repeat (10) @(negedge clk);
        supply_ok = 1'b1;
        repeat (P - 3) @(negedge clk);
        check("R7", rst_hi, 1'b1);
        while (rst_hi) @(negedge clk);
        // R10: the code written before the loss is still in use
        cur_req = "R10";
        run_len(1'b0, T00, "R10");
        run_len(1'b1, R, "R10");
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule